// File: doc/BRIEF.md
# Threshold-Triggered Transmit Frame FIFO

This block stages one outgoing Ethernet frame in a 2048-byte buffer. Software pushes 32-bit words through a data write strobe. The first word of a frame holds the payload length in its low 16 bits. That length counts neither the 14-byte header nor the length field itself. Every word after it is frame data. The block stores each word as four bytes and watches two conditions: a programmable fill threshold, counted in words, and a completion rule derived from the length.

When both conditions hold after a data write, the block streams the frame out on a byte-wide valid/ready interface with a last-byte marker. The frame can be zero-padded to the minimum Ethernet frame size. A transmit request strobe starts a send at any idle moment. While a frame streams out, the block is busy and ignores data writes. At the end of a send the buffer empties and a sticky empty flag rises. An oversize length word raises a sticky error flag. Acknowledging that error also flushes the buffer.

Top module: `tx_frame_fifo`

## Requirements
- R1: When the buffer holds no words, a written word whose bits [15:0] exceed 2032 is not stored, and the error flag `err_o` sets. The next accepted word is then taken as the length word.
- R2: An accepted word is stored as four bytes: byte k of the buffer fill is word bits [8k+7:8k], lowest byte first. Once 512 words (2048 bytes) are held, further data words are discarded.
- R3: A frame is complete when the stored byte count is at least min(length + 16 + (crc_auto_i ? 0 : 4), 2048).
- R4: The threshold register `thr` is 6 bits wide and resets to 63. Any value of 63 disables the threshold. For any other value, the threshold is reached when the stored word count is at least thr*8 + 1.
- R5: A data write that is not rejected starts a send in the following cycle (busy_o high) exactly when the threshold is reached and the frame is complete, counting the word just written.
- R6: A pulse on `send_i` while idle starts a send regardless of the threshold and completion rule.
- R7: The frame emitted is buffer bytes 2 onward, and it is length + 14 bytes long. With `pad_en_i` set and that count below 60, the bytes from length + 14 up to 59 are zero and the frame is exactly 60 bytes. The frame length never exceeds 2046.
- R8: After the last byte is accepted, the buffer holds zero words, busy_o falls and `empty_o` sets. `ack_empty_i` clears `empty_o`.
- R9: `ack_err_i` clears `err_o`. When idle, it also empties the buffer. A data write in the same cycle is ignored.
- R10: While busy_o is high, `tx_valid_o` is high, data writes are ignored, and a stalled byte (ready low) holds its data and last marker. `tx_last_o` marks the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Data word write strobe |
| wr_data_i | input | 32 | Data word; length in [15:0] for the first word |
| thr_we_i | input | 1 | Threshold register write strobe |
| thr_i | input | 6 | Threshold value (63 disables) |
| pad_en_i | input | 1 | Zero-pad short frames to 60 bytes |
| crc_auto_i | input | 1 | Automatic CRC on (no CRC words expected in buffer) |
| send_i | input | 1 | Transmit request strobe |
| ack_err_i | input | 1 | Clear error flag and flush buffer |
| ack_empty_i | input | 1 | Clear empty flag |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Output byte accepted |
| tx_data_o | output | 8 | Output byte |
| tx_last_o | output | 1 | Final byte of frame |
| busy_o | output | 1 | Frame streaming; writes ignored |
| err_o | output | 1 | Sticky oversize-length error |
| empty_o | output | 1 | Sticky send-finished flag |

## Verification
Two corner cases are hard to reach. One is the 2032-byte payload with automatic CRC off, where the completion count must saturate at the buffer size. The other is the full-buffer discard, where a 513th word must vanish. Both need more than 500 back-to-back writes under a chosen threshold and CRC setting. The bench drives them with directed frames at thresholds 0 and 63. The busy write lockout is only visible through frame content. The bench therefore starts a manual send with a single word held, so the frame reads stale bytes from an earlier frame. It then writes during a stall and checks that those stale bytes come out unchanged. Random frames mix length, padding, CRC mode and threshold, and a bench model predicts the exact write after which busy rises.

// File: rtl/tff_pkg.sv
`timescale 1ns/1ps
package tff_pkg;
  localparam int unsigned LEN_FIELD  = 2;   // length half-word ahead of frame
  localparam int unsigned HDR_BYTES  = 14;
  localparam int unsigned CRC_BYTES  = 4;
  localparam int unsigned MIN_FRAME  = 60;
  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/tff_store.sv
`timescale 1ns/1ps
module tff_store #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned BA_W  = 11
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [BA_W-3:0] waddr_i,
  input  logic [31:0]     wdata_i,
  input  logic [BA_W-1:0] raddr_i,
  output logic [7:0]      rbyte_o
);
  logic [31:0] mem_q [DEPTH];
  logic [31:0] rword;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rword   = mem_q[raddr_i[BA_W-1:2]];
  assign rbyte_o = rword[{raddr_i[1:0], 3'b000} +: 8];
endmodule

// File: rtl/tff_rules.sv
`timescale 1ns/1ps
module tff_rules
  import tff_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 2048,
  parameter int unsigned WC_W       = 10,
  parameter int unsigned THR_W      = 6
) (
  input  logic [WC_W-1:0]  wcnt_i,
  input  logic [15:0]      len_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             crc_auto_i,
  output logic             thr_hit_o,
  output logic             complete_o
);
  logic [17:0] need, need_cap, have, thr_words;

  assign need      = 18'(len_i) + 18'(LEN_FIELD + HDR_BYTES)
                   + (crc_auto_i ? 18'd0 : 18'(CRC_BYTES));
  assign need_cap  = (need > 18'(FIFO_BYTES)) ? 18'(FIFO_BYTES) : need;
  assign have      = 18'({wcnt_i, 2'b00});
  assign thr_words = 18'({thr_i, 3'b000}) + 18'd1;

  assign thr_hit_o  = (thr_i != '1) && (18'(wcnt_i) >= thr_words);
  assign complete_o = have >= need_cap;
endmodule

// File: rtl/tff_stream.sv
`timescale 1ns/1ps
module tff_stream
  import tff_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 2048,
  parameter int unsigned BA_W       = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [15:0]     len_i,
  input  logic            pad_en_i,
  input  logic            ready_i,
  output logic [BA_W-1:0] rd_addr_o,
  input  logic [7:0]      rd_byte_i,
  output logic            valid_o,
  output logic [7:0]      data_o,
  output logic            last_o,
  output logic            done_o
);
  localparam int unsigned MAX_FRAME = FIFO_BYTES - LEN_FIELD;

  logic            busy_q;
  logic [BA_W-1:0] idx_q, flen_q, dend_q;
  logic [16:0]     base, padded, flen_c, dend_c;

  assign base   = 17'(len_i) + 17'(HDR_BYTES);
  assign padded = (pad_en_i && base < 17'(MIN_FRAME)) ? 17'(MIN_FRAME) : base;
  assign flen_c = (padded > 17'(MAX_FRAME)) ? 17'(MAX_FRAME) : padded;
  assign dend_c = (base > 17'(MAX_FRAME)) ? 17'(MAX_FRAME) : base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      flen_q <= '0;
      dend_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      flen_q <= flen_c[BA_W-1:0];
      dend_q <= dend_c[BA_W-1:0];
    end else if (busy_q && ready_i) begin
      if (last_o) busy_q <= 1'b0;
      else        idx_q  <= idx_q + 1'b1;
    end
  end

  assign valid_o   = busy_q;
  assign last_o    = busy_q && (idx_q == flen_q - 1'b1);
  assign done_o    = busy_q && ready_i && last_o;
  assign rd_addr_o = idx_q + BA_W'(LEN_FIELD);
  assign data_o    = (idx_q < dend_q) ? rd_byte_i : 8'h00;  // pad bytes read as zero
endmodule

// File: rtl/tx_frame_fifo.sv
`timescale 1ns/1ps
module tx_frame_fifo
  import tff_pkg::*;
#(
  parameter int unsigned FIFO_BYTES  = 2048,
  parameter int unsigned MAX_PAYLOAD = 2032,
  parameter int unsigned THR_W       = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             pad_en_i,
  input  logic             crc_auto_i,
  input  logic             send_i,
  input  logic             ack_err_i,
  input  logic             ack_empty_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_last_o,
  output logic             busy_o,
  output logic             err_o,
  output logic             empty_o
);
  localparam int unsigned WORDS = FIFO_BYTES / WORD_BYTES;
  localparam int unsigned WC_W  = $clog2(WORDS + 1);
  localparam int unsigned BA_W  = $clog2(FIFO_BYTES);

  logic [WC_W-1:0]  wcnt_q, wcnt_nx;
  logic [15:0]      len_q, len_eff;
  logic [THR_W-1:0] thr_q;
  logic             err_q, empty_q;
  logic             first_wr, wr_ok, len_bad, room, store;
  logic             thr_hit, complete, auto_go, start, done;
  logic [BA_W-1:0]  rd_addr;
  logic [7:0]       rd_byte;

  assign first_wr = (wcnt_q == '0);
  assign wr_ok    = wr_en_i && !busy_o && !ack_err_i;
  assign len_bad  = first_wr && (wr_data_i[15:0] > MAX_PAYLOAD[15:0]);
  assign room     = (wcnt_q < WC_W'(WORDS));
  assign store    = wr_ok && !len_bad && room;
  assign wcnt_nx  = store ? wcnt_q + 1'b1 : wcnt_q;
  assign len_eff  = (store && first_wr) ? wr_data_i[15:0] : len_q;
  assign auto_go  = wr_ok && !len_bad && thr_hit && complete;
  assign start    = !busy_o && (send_i || auto_go);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q  <= '0;
      len_q   <= '0;
      thr_q   <= '1;
      err_q   <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      if (done || (ack_err_i && !busy_o)) wcnt_q <= '0;
      else                                wcnt_q <= wcnt_nx;
      if (store && first_wr) len_q <= wr_data_i[15:0];
      if (thr_we_i) thr_q <= thr_i;
      if (wr_ok && len_bad) err_q <= 1'b1;
      else if (ack_err_i)   err_q <= 1'b0;
      if (done)             empty_q <= 1'b1;
      else if (ack_empty_i) empty_q <= 1'b0;
    end
  end

  tff_store #(.DEPTH(WORDS), .BA_W(BA_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (store),
    .waddr_i (wcnt_q[BA_W-3:0]),
    .wdata_i (wr_data_i),
    .raddr_i (rd_addr),
    .rbyte_o (rd_byte)
  );

  tff_rules #(.FIFO_BYTES(FIFO_BYTES), .WC_W(WC_W), .THR_W(THR_W)) u_rules (
    .wcnt_i     (wcnt_nx),
    .len_i      (len_eff),
    .thr_i      (thr_q),
    .crc_auto_i (crc_auto_i),
    .thr_hit_o  (thr_hit),
    .complete_o (complete)
  );

  tff_stream #(.FIFO_BYTES(FIFO_BYTES), .BA_W(BA_W)) u_stream (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .len_i     (len_eff),
    .pad_en_i  (pad_en_i),
    .ready_i   (tx_ready_i),
    .rd_addr_o (rd_addr),
    .rd_byte_i (rd_byte),
    .valid_o   (tx_valid_o),
    .data_o    (tx_data_o),
    .last_o    (tx_last_o),
    .done_o    (done)
  );

  assign busy_o  = tx_valid_o;
  assign err_o   = err_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/tff_checker.sv
`timescale 1ns/1ps
module tff_checker #(
  parameter int unsigned WC_W        = 10,
  parameter int unsigned WORDS       = 512,
  parameter int unsigned MAX_PAYLOAD = 2032
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [31:0]     wr_data_i,
  input logic            ack_err_i,
  input logic            tx_valid_o,
  input logic            tx_ready_i,
  input logic [7:0]      tx_data_o,
  input logic            tx_last_o,
  input logic            busy_o,
  input logic            err_o,
  input logic            empty_o,
  input logic [WC_W-1:0] wcnt_q
);
  logic fin;
  assign fin = tx_valid_o && tx_ready_i && tx_last_o;

  AST_OVERSIZE_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_o && !ack_err_i && wcnt_q == '0 && wr_data_i[15:0] > MAX_PAYLOAD[15:0])
    |=> (err_o && wcnt_q == '0)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= WC_W'(WORDS)); // R2

  AST_DONE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> (empty_o && !busy_o && wcnt_q == '0)); // R8

  AST_ACK_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_err_i && !busy_o) |=> (!err_o && wcnt_q == '0)); // R9

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o))); // R10

  AST_BUSY_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i && !fin) |=> $stable(wcnt_q)); // R10
endmodule

bind tx_frame_fifo tff_checker #(.WC_W(WC_W), .WORDS(WORDS), .MAX_PAYLOAD(MAX_PAYLOAD)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .ack_err_i  (ack_err_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .tx_last_o  (tx_last_o),
  .busy_o     (busy_o),
  .err_o      (err_o),
  .empty_o    (empty_o),
  .wcnt_q     (wcnt_q)
);

// File: tb/tb_tx_frame_fifo.sv
`timescale 1ns/1ps
module tb_tx_frame_fifo;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en = 0, thr_we = 0, pad_en = 0, crc_auto = 1, send = 0, ack_err = 0, ack_empty = 0;
  logic tx_ready = 0;
  logic [31:0] wr_data = '0;
  logic [5:0] thr_in = '0;
  logic tx_valid, tx_last, busy, err, empty;
  logic [7:0] tx_data;

  always #10 clk = ~clk;

  tx_frame_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .thr_we_i(thr_we), .thr_i(thr_in), .pad_en_i(pad_en), .crc_auto_i(crc_auto),
    .send_i(send), .ack_err_i(ack_err), .ack_empty_i(ack_empty),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .busy_o(busy), .err_o(err), .empty_o(empty)
  );

  int n_chk = 0, n_fail = 0;
  byte unsigned mb [2048];
  int mcnt = 0, mlen = 0, cur_thr = 63;
  bit merr = 0, cur_crc = 1;

  function automatic int need_bytes(int len, bit crc);
    int n = len + 16 + (crc ? 0 : 4);
    return (n > 2048) ? 2048 : n;
  endfunction

  function automatic int frame_bytes(int len, bit pad);
    int n = len + 14;
    if (pad && n < 60) n = 60;
    if (n > 2046) n = 2046;
    return n;
  endfunction

  function automatic bit thr_ok(int t, int words);
    return (t < 63) && (words >= t * 8 + 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_thr(input int t);
    @(negedge clk); thr_we = 1; thr_in = 6'(t);
    @(negedge clk); thr_we = 0;
    cur_thr = t;
  endtask

  task automatic wr_word(input logic [31:0] d, input string req, output bit sent);
    bit rej;
    sent = 0;
    rej = (mcnt == 0) && (d[15:0] > 16'd2032);
    if (rej) merr = 1;
    else begin
      if (mcnt == 0) mlen = int'(d[15:0]);
      if (mcnt < 512) begin
        for (int b = 0; b < 4; b++) mb[mcnt*4 + b] = d[8*b +: 8];
        mcnt++;
      end
      sent = thr_ok(cur_thr, mcnt) && (mcnt * 4 >= need_bytes(mlen, cur_crc));
    end
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
    check(busy == sent, req, "busy after write", int'(busy), int'(sent));
    check(err == merr, "R1", "error flag", int'(err), int'(merr));
  endtask

  task automatic recv(input bit pad, input string req);
    int exp_n, got, e, ga, ge, guard;
    bit bad, fin;
    exp_n = frame_bytes(mlen, pad);
    got = 0; ga = 0; ge = 0; guard = 0; bad = 0; fin = 0;
    while (!fin && guard < 20000) begin
      @(negedge clk);
      tx_ready = ($urandom % 4) != 0;
      #1;
      guard++;
      if (tx_valid && tx_ready) begin
        e = (got < mlen + 14) ? int'(mb[got + 2]) : 0;
        if (int'(tx_data) != e && !bad) begin bad = 1; ga = int'(tx_data); ge = e; end
        if (tx_last) fin = 1;
        got++;
      end
    end
    @(negedge clk); tx_ready = 0;
    check(got == exp_n, req, "frame length", got, exp_n);
    check(!bad, req, "frame byte", ga, ge);
    check(!busy && empty, "R8", "idle and empty after send", int'(busy), 0);
    mcnt = 0;
    @(negedge clk); ack_empty = 1;
    @(negedge clk); ack_empty = 0;
    check(!empty, "R8", "empty flag acknowledged", int'(empty), 0);
  endtask

  task automatic run_frame(input int len, input bit pad, input bit crc, input int t,
                           input int extra, input string req);
    bit sent;
    int n, needw, target;
    pad_en = pad; crc_auto = crc; cur_crc = crc;
    if (t >= 0) set_thr(t);
    needw  = (need_bytes(len, crc) + 3) / 4;
    target = needw;
    if (cur_thr < 63 && cur_thr * 8 + 1 > target) target = cur_thr * 8 + 1;
    target += extra;
    wr_word({16'($urandom), 16'(len)}, req, sent);
    n = 1;
    while (!sent && n < target) begin
      wr_word($urandom, req, sent);
      n++;
    end
    if (!sent) begin
      @(negedge clk); send = 1;
      @(negedge clk); send = 0;
      check(busy == 1'b1, "R6", "manual send starts", int'(busy), 1);
    end
    recv(pad, req);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit s;
    void'($urandom(32'd20240517));
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!tx_valid && !busy && !err && !empty, "R10", "reset outputs idle", int'(tx_valid | busy | err | empty), 0);

    // R4: reset threshold disables auto send
    run_frame(4, 0, 1, -1, 0, "R4");
    // R1: oversize length rejected, next word is the length word
    pad_en = 0; crc_auto = 1; cur_crc = 1;
    set_thr(0);
    wr_word(32'h0000_07F1, "R1", s);
    run_frame(10, 0, 1, 0, 0, "R1");
    // R9: ack flushes partial frame
    set_thr(63);
    wr_word(32'hABCD_0008, "R9", s);
    wr_word(32'h1122_3344, "R9", s);
    @(negedge clk); ack_err = 1;
    @(negedge clk); ack_err = 0;
    mcnt = 0; merr = 0;
    check(!err, "R9", "error flag cleared", int'(err), 0);
    run_frame(6, 0, 1, 0, 0, "R9");
    // R7 padding
    run_frame(10, 1, 1, 0, 0, "R7");
    run_frame(10, 0, 1, 0, 0, "R7");
    run_frame(46, 1, 1, 0, 0, "R7");
    run_frame(47, 1, 1, 0, 0, "R7");
    // R3 CRC-off completion
    run_frame(4, 0, 0, 0, 0, "R3");
    // R4/R5 threshold settings
    run_frame(4, 0, 1, 2, 0, "R4");
    run_frame(4, 0, 1, 5, 0, "R5");
    run_frame(100, 1, 0, 1, 0, "R5");
    // R3/R7 2032 payload, CRC off, saturated completion
    run_frame(2032, 0, 0, 0, 0, "R3");
    // R2 full buffer discards 513th word
    run_frame(2032, 0, 1, 63, 1, "R2");
    // R10 busy lockout: one word held, frame reads stale bytes
    pad_en = 0;
    wr_word({16'h5A5A, 16'd8}, "R10", s);
    @(negedge clk); send = 1;
    @(negedge clk); send = 0;
    check(busy == 1'b1, "R6", "manual send with one word", int'(busy), 1);
    @(negedge clk); wr_en = 1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); wr_en = 0;
    check(busy == 1'b1 && tx_valid, "R10", "still busy while stalled", int'(busy), 1);
    recv(0, "R10");
    // random mix
    for (int i = 0; i < 25; i++) begin
      int len, t, sel;
      sel = $urandom % 5;
      t   = (sel == 4) ? 63 : sel;
      len = ($urandom % 8 == 0) ? int'($urandom % 600) : int'($urandom % 120);
      run_frame(len, 1'($urandom), 1'($urandom), t, 0, "R5");
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule